// File: doc/BRIEF.md
# Fractional Clock Prescaler

This block turns a fast input clock into a slower enable stream for a serial interface's baud generator. The average division ratio is an integer divisor from 2 to 8 plus a fraction in steps of 1/32. The fraction is made by lengthening a chosen number N of output periods by one input clock in every run of 32 output periods. A phase accumulator spreads those lengthened periods as evenly as the step allows.

One 8-bit control register sets the block. The top three bits pick the divisor and the low five bits hold N. The register can be written and read back at any time. A new value is taken up only at the next output-period boundary, so the period in progress always runs to its full length. Divisor code zero selects pass-through. In that mode the enable is held high on every input clock, and the fraction logic is idle whatever N is.

Top module: `frac_prescaler`

## Requirements
- R1: After reset the control register reads 0x00 and `en_o` is high, because code zero is pass-through.
- R2: A write loads the control register, and `reg_rdata_o` returns the written byte from the following cycle onward. Bits 7:5 are the divisor code k and bits 4:0 are the insertion count N.
- R3: For k from 1 to 7 with N = 0, `en_o` is a one-cycle pulse that repeats every k+1 input clocks.
- R4: For k = 0, `en_o` is high on every input clock, whatever value N holds.
- R5: Any 32 consecutive output periods run under one setting last 32·(k+1)+N input clocks in total.
- R6: A register change takes effect at the next `en_o` pulse. The period already running completes with the length set by the old value.
- R7: After a change to a new value with k ≠ 0, the j-th new period (j = 1, 2, …) lasts k+2 clocks when floor(j·N/32) > floor((j−1)·N/32). Otherwise it lasts k+1 clocks. So the phase restarts from zero at every change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| en_o | output | 1 | Divided enable pulse, or held high in pass-through |

## Verification
The bench measures every period of full 32-period frames. A design that lost or doubled an insertion, or counted a divisor one off, would miss the frame total. A design that bunched the insertions or failed to clear the phase on a change would miss the per-period lengths. A change written in the middle of an 8-clock period must leave that period at 8 clocks; a design that applied it at once would cut the period short. Pass-through is checked with a nonzero insertion field, which a design that failed to gate the fraction logic would turn into gaps in the enable.

// File: rtl/presc_pkg.sv
package presc_pkg;
  parameter int unsigned SEL_W  = 3;
  parameter int unsigned INS_W  = 5;
  parameter int unsigned CTRL_W = SEL_W + INS_W;
  parameter int unsigned CNT_W  = $clog2((2 ** SEL_W) + 1);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [INS_W-1:0] ins;
  } cfg_t;
endpackage

// File: rtl/presc_ctrl_reg.sv
module presc_ctrl_reg
  import presc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  cfg_t wdata_i,
  input  logic load_i,
  output cfg_t q_o,
  output cfg_t act_o,
  output logic chg_o
);
  cfg_t q_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (we_i) q_q <= wdata_i;
  end

  // active copy only moves at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (load_i) act_q <= q_q;
  end

  assign q_o   = q_q;
  assign act_o = act_q;
  assign chg_o = load_i && (q_q != act_q);

  assert_write_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));

  assert_hold_mid_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_o));
endmodule

// File: rtl/presc_phase_accum.sv
module presc_phase_accum
  import presc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             chg_i,
  input  cfg_t             nxt_i,
  input  logic [INS_W-1:0] act_ins_i,
  output logic             carry_o
);
  logic [INS_W-1:0] acc_q, frame_q, acc_base, frame_base;
  logic [INS_W:0]   sum;
  logic             nxt_bypass;

  assign nxt_bypass = (nxt_i.sel == '0);
  assign acc_base   = chg_i ? '0 : acc_q;
  assign frame_base = chg_i ? '0 : frame_q;
  assign sum        = {1'b0, acc_base} + {1'b0, nxt_i.ins};
  assign carry_o    = !nxt_bypass && sum[INS_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      frame_q <= '0;
    end else if (load_i) begin
      if (nxt_bypass) begin
        acc_q   <= '0;
        frame_q <= '0;
      end else begin
        acc_q   <= sum[INS_W-1:0];
        frame_q <= frame_base + 1'b1;
      end
    end
  end

  logic [2*INS_W-1:0] phase_ref;
  always_comb phase_ref = {{INS_W{1'b0}}, frame_q} * {{INS_W{1'b0}}, act_ins_i};

  // phase equals periods-into-frame times N, modulo frame length
  assert_phase_track_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q == phase_ref[INS_W-1:0]);
endmodule

// File: rtl/presc_period_cnt.sv
module presc_period_cnt
  import presc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] act_sel_i,
  input  logic [SEL_W-1:0] nxt_sel_i,
  input  logic             carry_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;

  assign en_o = (act_sel_i == '0) || (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (en_o) begin
      if (nxt_sel_i == '0) cnt_q <= '0;
      else cnt_q <= CNT_W'(nxt_sel_i) + CNT_W'(carry_i);
    end else cnt_q <= cnt_q - 1'b1;
  end

  assert_count_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && (nxt_sel_i != '0)) |=> !en_o);

  assert_len_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(2 ** SEL_W));
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler
  import presc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  output logic              en_o
);
  cfg_t q, act;
  logic chg, carry, load;

  assign load = en_o;

  presc_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (cfg_t'(reg_wdata_i)),
    .load_i  (load),
    .q_o     (q),
    .act_o   (act),
    .chg_o   (chg)
  );

  presc_phase_accum u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .chg_i     (chg),
    .nxt_i     (q),
    .act_ins_i (act.ins),
    .carry_o   (carry)
  );

  presc_period_cnt u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_sel_i (act.sel),
    .nxt_sel_i (q.sel),
    .carry_i   (carry),
    .en_o      (en_o)
  );

  assign reg_rdata_o = q;
endmodule

// File: tb/frac_prescaler_tb_top.sv
module frac_prescaler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] act_cfg = 8'h00;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  frac_prescaler dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .en_o        (en_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stretched(input int j, input int n);
    return (((j * n) / 32) != (((j - 1) * n) / 32)) ? 1 : 0;
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk_i);
    reg_we_i = 1'b1;
    reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    check(reg_rdata_o == v, "R2 readback", int'(reg_rdata_o), int'(v));
  endtask

  task automatic wait_boundary();
    while (!en_o) @(negedge clk_i);
  endtask

  task automatic period_len(output int len);
    len = 0;
    do begin
      @(negedge clk_i);
      len++;
    end while (!en_o);
  endtask

  task automatic run_cfg(input logic [7:0] v);
    int pd, n, len, total;
    bit fresh;
    fresh = (v != act_cfg);
    write_cfg(v);
    wait_boundary();
    act_cfg = v;
    pd = int'(v[7:5]) + 1;
    n = int'(v[4:0]);
    total = 0;
    for (int j = 1; j <= 32; j++) begin
      period_len(len);
      total += len;
      if (fresh) check(len == pd + stretched(j, n), "R7 period length", len, pd + stretched(j, n));
      else check(len == pd || len == pd + 1, "R7 period range", len, pd);
    end
    check(total == 32 * pd + n, "R5 frame total", total, 32 * pd + n);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    logic [7:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    check(reg_rdata_o == 8'h00, "R1 reset register", int'(reg_rdata_o), 0);
    check(en_o == 1'b1, "R1 reset enable", int'(en_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(en_o == 1'b1, "R1 enable after reset", int'(en_o), 1);

    // R3: integer divisors, no insertion
    for (int k = 1; k <= 7; k++) run_cfg({k[2:0], 5'd0});

    // R4: pass-through ignores insertion field
    write_cfg({3'd0, 5'd19});
    wait_boundary();
    act_cfg = {3'd0, 5'd19};
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      check(en_o == 1'b1, "R4 pass-through high", int'(en_o), 1);
    end

    // corner cases of the fraction
    run_cfg({3'd7, 5'd31});
    run_cfg({3'd1, 5'd1});
    run_cfg({3'd3, 5'd16});
    run_cfg({3'd3, 5'd16});

    // R6: change mid-period keeps current period intact
    run_cfg({3'd7, 5'd0});
    @(negedge clk_i);
    reg_we_i = 1'b1;
    reg_wdata_i = {3'd1, 5'd0};
    @(negedge clk_i);
    reg_we_i = 1'b0;
    len = 2;
    while (!en_o) begin
      @(negedge clk_i);
      len++;
    end
    check(len == 8, "R6 old period completes", len, 8);
    act_cfg = {3'd1, 5'd0};
    period_len(len);
    check(len == 2, "R6 new period applied", len, 2);

    // random settings
    for (int r = 0; r < 10; r++) begin
      v[7:5] = 3'($urandom_range(1, 7));
      v[4:0] = 5'($urandom_range(0, 31));
      run_cfg(v);
    end

    // back to pass-through
    write_cfg({3'd0, 5'd7});
    wait_boundary();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check(en_o == 1'b1, "R4 pass-through return", int'(en_o), 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule